// File: doc/BRIEF.md
# Status-Driven Egress Burst Dispatcher

This block picks the destination and the burst ceiling for egress traffic on each of 64 logical channels. Each channel has one descriptor held in a table. A plain register write port loads the table, and the same port reads it back. A descriptor holds a two-bit route code and two four-bit burst fields. One burst field applies when the far side reports the channel as hungry. The other applies when it reports the channel as starving. A field value N allows a burst of (N+1)×16 bytes.

An upstream scheduler grants one channel at a time on a valid/ready handshake. On the clock edge that accepts a grant, the block samples two things: the descriptor of the granted channel and that channel's live two-bit FIFO status. From these it produces a dispatch record. The record carries the channel, the route and the byte limit, and it is offered on a second valid/ready handshake. The downstream consumer can stall that record for as long as it needs to. While the record is stalled, it stays frozen and new grants are held off.

A descriptor write that would set the starving ceiling below the hungry ceiling is refused. A refused write also sets a sticky error flag.

Top module: `burst_dispatch`

## Requirements
- R1: After reset, every descriptor reads back as 0x000003FF: both burst fields are 0xF and the route is 11 (discard). cfg_err is 0, dsp_valid is 0 and gnt_ready is 1.
- R2: A write with cfg_we high stores the following fields into descriptor cfg_addr: cfg_wdata bits 3:0 as the hungry field, bits 7:4 as the starving field and bits 9:8 as the route. cfg_rdata shows descriptor cfg_addr combinationally. Its bits 31:10 always read 0, and the written reserved bits are dropped.
- R3: A write whose starving field is less than its hungry field leaves the descriptor unchanged and sets cfg_err. cfg_err then stays 1 until reset. A write with equal fields is accepted.
- R4: A burst field value N gives a byte limit of (N+1)×16. N=0 gives 16, N=7 gives 128 and N=15 gives 256.
- R5: Each channel c reads its status from fifo_status[2c+1:2c]. Status 00 (starving) selects the starving field. Status 01 (hungry) selects the hungry field.
- R6: A grant for a channel whose status is 10 (satisfied) or 11 (treated as satisfied) is consumed, and no dispatch record is produced for it.
- R7: The route code is passed to dsp_route. Route 00 is the aggregate egress port, 01 the associated narrow port, 10 microprocessor capture and 11 discard. Only route 00 carries a nonzero dsp_limit; every other route gives dsp_limit 0.
- R8: A grant is accepted on a rising edge where gnt_valid and gnt_ready are both 1. The resulting record appears on dsp_* right after that edge. The descriptor used is the one held before that edge, so a write on the same edge is not yet seen.
- R9: While dsp_valid is 1 and dsp_ready is 0, the dsp_* outputs hold steady and gnt_ready is 0. When dsp_ready is 1, a new grant can be accepted on the same edge that retires the current record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_addr | input | 6 | Descriptor index for write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| cfg_err | output | 1 | Sticky flag for a refused write |
| fifo_status | input | 128 | Two status bits per channel |
| gnt_valid | input | 1 | Grant offered |
| gnt_ready | output | 1 | Grant can be taken |
| gnt_chan | input | 6 | Granted channel |
| dsp_valid | output | 1 | Dispatch record valid |
| dsp_ready | input | 1 | Consumer takes the record |
| dsp_chan | output | 6 | Channel of the record |
| dsp_route | output | 2 | Route code of the record |
| dsp_limit | output | 9 | Burst ceiling in bytes |

## Verification
The bench covers both ends of the burst encoding. If the +1 were dropped, N=0 would give 0 bytes and N=15 would give 240 bytes.

It checks the starving and hungry selection on the same channel. Swapped fields would show up as 64 and 128 bytes trading places.

It checks the refused write two ways: the descriptor must stay unchanged, and the flag must stay set after a later legal write. An equal-field write must still be accepted.

It also covers three timing cases:
- A write and a grant on the same edge, to catch a design that forwards the new descriptor too early.
- Satisfied grants, which a faulty design would still dispatch.
- A stalled consumer, where a faulty design would drop or overwrite the pending record.

// File: rtl/bdisp_pkg.sv
package bdisp_pkg;
  localparam int BURST_W   = 4;
  localparam int UNIT_LOG2 = 4;
  localparam int STAT_W    = 2;
  localparam int DATA_W    = 32;
  localparam int LIMIT_W   = BURST_W + 1 + UNIT_LOG2;

  typedef enum logic [1:0] {
    RT_AGG     = 2'b00,
    RT_NARROW  = 2'b01,
    RT_CAPTURE = 2'b10,
    RT_DROP    = 2'b11
  } route_t;

  typedef enum logic [1:0] {
    ST_STARVE = 2'b00,
    ST_HUNGRY = 2'b01,
    ST_SAT    = 2'b10,
    ST_RSVD   = 2'b11
  } fstat_t;

  // packed so that bits 9:8 route, 7:4 starving, 3:0 hungry
  typedef struct packed {
    route_t             route;
    logic [BURST_W-1:0] starve;
    logic [BURST_W-1:0] hungry;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  localparam desc_t DESC_RESET = '{route: RT_DROP,
                                   starve: {BURST_W{1'b1}},
                                   hungry: {BURST_W{1'b1}}};
endpackage

// File: rtl/bdisp_table.sv
module bdisp_table
  import bdisp_pkg::*;
#(
  parameter int CHANNELS = 64,
  parameter int CH_W     = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_addr,
  output desc_t             rd_entry,
  input  logic [CH_W-1:0]   lk_addr,
  output desc_t             lk_entry,
  output logic              err
);
  desc_t entries [CHANNELS];
  desc_t wr_desc;
  logic  wr_ok;

  always_comb begin
    wr_desc = desc_t'(wr_data[DESC_W-1:0]);
    wr_ok   = wr_en && (wr_desc.starve >= wr_desc.hungry);
  end

  for (genvar i = 0; i < CHANNELS; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entries[i] <= DESC_RESET;
      else if (wr_ok && (wr_addr == CH_W'(i)))
        entries[i] <= wr_desc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      err <= 1'b0;
    else if (wr_en && !wr_ok)
      err <= 1'b1;
  end

  assign rd_entry = entries[rd_addr];
  assign lk_entry = entries[lk_addr];
endmodule

// File: rtl/bdisp_limit.sv
module bdisp_limit
  import bdisp_pkg::*;
(
  input  desc_t              entry,
  input  logic [STAT_W-1:0]  status,
  output route_t             route,
  output logic [LIMIT_W-1:0] limit,
  output logic               drop
);
  logic [BURST_W-1:0] field;
  logic [BURST_W:0]   units;

  always_comb begin
    route = entry.route;
    drop  = 1'b0;
    field = '0;
    unique case (fstat_t'(status))
      ST_STARVE: field = entry.starve;
      ST_HUNGRY: field = entry.hungry;
      default:   drop  = 1'b1;
    endcase
    units = {1'b0, field} + 1'b1;
    if (drop || entry.route != RT_AGG)
      limit = '0;
    else
      limit = {units, {UNIT_LOG2{1'b0}}};
  end
endmodule

// File: rtl/bdisp_out_stage.sv
module bdisp_out_stage
  import bdisp_pkg::*;
#(
  parameter int CH_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_drop,
  input  logic [CH_W-1:0]    in_chan,
  input  route_t             in_route,
  input  logic [LIMIT_W-1:0] in_limit,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CH_W-1:0]    out_chan,
  output route_t             out_route,
  output logic [LIMIT_W-1:0] out_limit
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_route <= RT_DROP;
      out_limit <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid && !in_drop;
      if (in_valid && !in_drop) begin
        out_chan  <= in_chan;
        out_route <= in_route;
        out_limit <= in_limit;
      end
    end
  end
endmodule

// File: rtl/burst_dispatch.sv
module burst_dispatch
  import bdisp_pkg::*;
#(
  parameter int CHANNELS = 64,
  parameter int CH_W     = $clog2(CHANNELS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [CH_W-1:0]            cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  output logic [DATA_W-1:0]          cfg_rdata,
  output logic                       cfg_err,
  input  logic [CHANNELS*STAT_W-1:0] fifo_status,
  input  logic                       gnt_valid,
  output logic                       gnt_ready,
  input  logic [CH_W-1:0]            gnt_chan,
  output logic                       dsp_valid,
  input  logic                       dsp_ready,
  output logic [CH_W-1:0]            dsp_chan,
  output logic [1:0]                 dsp_route,
  output logic [LIMIT_W-1:0]         dsp_limit
);
  desc_t              rd_entry, lk_entry;
  logic [STAT_W-1:0]  gnt_stat;
  route_t             sel_route, out_route;
  logic [LIMIT_W-1:0] sel_limit;
  logic               sel_drop;

  bdisp_table #(.CHANNELS(CHANNELS), .CH_W(CH_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .rd_addr(cfg_addr), .rd_entry(rd_entry),
    .lk_addr(gnt_chan), .lk_entry(lk_entry),
    .err(cfg_err)
  );

  assign cfg_rdata = {{(DATA_W-DESC_W){1'b0}}, rd_entry};
  assign gnt_stat  = fifo_status[gnt_chan*STAT_W +: STAT_W];

  bdisp_limit u_limit (
    .entry(lk_entry), .status(gnt_stat),
    .route(sel_route), .limit(sel_limit), .drop(sel_drop)
  );

  bdisp_out_stage #(.CH_W(CH_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(gnt_valid), .in_ready(gnt_ready), .in_drop(sel_drop),
    .in_chan(gnt_chan), .in_route(sel_route), .in_limit(sel_limit),
    .out_valid(dsp_valid), .out_ready(dsp_ready),
    .out_chan(dsp_chan), .out_route(out_route), .out_limit(dsp_limit)
  );

  assign dsp_route = out_route;
endmodule

// File: rtl/bdisp_checker.sv
module bdisp_checker
  import bdisp_pkg::*;
#(
  parameter int CHANNELS = 64,
  parameter int CH_W     = $clog2(CHANNELS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_we,
  input logic [DATA_W-1:0]          cfg_wdata,
  input logic                       cfg_err,
  input logic [CHANNELS*STAT_W-1:0] fifo_status,
  input logic                       gnt_valid,
  input logic                       gnt_ready,
  input logic [CH_W-1:0]            gnt_chan,
  input logic                       dsp_valid,
  input logic                       dsp_ready,
  input logic [CH_W-1:0]            dsp_chan,
  input logic [1:0]                 dsp_route,
  input logic [LIMIT_W-1:0]         dsp_limit
);
  localparam int MAX_LIMIT = 1 << (BURST_W + UNIT_LOG2);
  logic [STAT_W-1:0] chk_stat;
  assign chk_stat = fifo_status[gnt_chan*STAT_W +: STAT_W];

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_chan) &&
                                   $stable(dsp_route) && $stable(dsp_limit)));
  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready) |-> !gnt_ready);
  // R7
  route_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && dsp_route != 2'b00) |-> (dsp_limit == '0));
  // R4
  limit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && dsp_route == 2'b00) |->
      (dsp_limit[UNIT_LOG2-1:0] == '0 && dsp_limit != '0 &&
       int'(dsp_limit) <= MAX_LIMIT));
  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R3
  bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_wdata[7:4] < cfg_wdata[3:0])) |=> cfg_err);
  // R6
  sat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_ready && chk_stat[1]) |=> !dsp_valid);
  // R8
  accept_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_ready && !chk_stat[1]) |=>
      (dsp_valid && dsp_chan == $past(gnt_chan)));
endmodule

bind burst_dispatch bdisp_checker #(.CHANNELS(CHANNELS), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_err(cfg_err), .fifo_status(fifo_status),
  .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_chan(gnt_chan),
  .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_chan(dsp_chan),
  .dsp_route(dsp_route), .dsp_limit(dsp_limit)
);

// File: tb/burst_dispatch_test.sv
module burst_dispatch_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [5:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic         cfg_err;
  logic [127:0] fifo_status = '0;
  logic         gnt_valid = 1'b0;
  logic         gnt_ready;
  logic [5:0]   gnt_chan = '0;
  logic         dsp_valid;
  logic         dsp_ready = 1'b1;
  logic [5:0]   dsp_chan;
  logic [1:0]   dsp_route;
  logic [8:0]   dsp_limit;

  int checks = 0;
  int fails  = 0;

  burst_dispatch uut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic set_stat(int ch, logic [1:0] s);
    fifo_status[ch*2 +: 2] = s;
  endtask

  task automatic grant(logic [5:0] ch);
    @(negedge clk);
    gnt_valid = 1'b1; gnt_chan = ch;
    @(posedge clk);
    @(negedge clk);
    gnt_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 dsp_valid", dsp_valid, 0);
    chk("R1 gnt_ready", gnt_ready, 1);
    rd(0, d);  chk("R1 entry0", d, 32'h3FF);
    rd(37, d); chk("R1 entry37", d, 32'h3FF);
    rd(63, d); chk("R1 entry63", d, 32'h3FF);
  endtask

  task automatic t_write();
    logic [31:0] d;
    wr(3, 32'hFFFF_FC73);
    rd(3, d); chk("R2 readback reserved dropped", d, 32'h073);
    rd(4, d); chk("R2 neighbour untouched", d, 32'h3FF);
  endtask

  task automatic t_reject();
    logic [31:0] d;
    wr(3, 32'h13A);
    rd(3, d); chk("R3 refused entry unchanged", d, 32'h073);
    chk("R3 cfg_err set", cfg_err, 1);
    wr(7, 32'h155);
    rd(7, d); chk("R3 equal fields accepted", d, 32'h155);
    chk("R3 cfg_err sticky", cfg_err, 1);
  endtask

  task automatic t_limits();
    set_stat(3, 2'b01); grant(3);
    chk("R5 hungry valid", dsp_valid, 1);
    chk("R5 hungry limit", dsp_limit, 64);
    set_stat(3, 2'b00); grant(3);
    chk("R5 starving limit", dsp_limit, 128);
    chk("R8 chan", dsp_chan, 3);
    wr(10, 32'h0F0);
    set_stat(10, 2'b01); grant(10);
    chk("R4 N=0 limit", dsp_limit, 16);
    set_stat(10, 2'b00); grant(10);
    chk("R4 N=15 limit", dsp_limit, 256);
  endtask

  task automatic t_routes();
    wr(20, 32'h1FF); set_stat(20, 2'b00); grant(20);
    chk("R7 narrow route", dsp_route, 1);
    chk("R7 narrow limit", dsp_limit, 0);
    wr(21, 32'h2FF); set_stat(21, 2'b01); grant(21);
    chk("R7 capture route", dsp_route, 2);
    chk("R7 capture limit", dsp_limit, 0);
    set_stat(63, 2'b00); grant(63);
    chk("R7 discard valid", dsp_valid, 1);
    chk("R7 discard route", dsp_route, 3);
    chk("R7 discard limit", dsp_limit, 0);
  endtask

  task automatic t_sat();
    set_stat(3, 2'b10); grant(3);
    chk("R6 satisfied dropped", dsp_valid, 0);
    set_stat(3, 2'b11); grant(3);
    chk("R6 status 11 dropped", dsp_valid, 0);
  endtask

  task automatic t_same_edge();
    set_stat(10, 2'b00);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 10; cfg_wdata = 32'h010;
    gnt_valid = 1'b1; gnt_chan = 10;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; gnt_valid = 1'b0;
    chk("R8 old descriptor used", dsp_limit, 256);
    grant(10);
    chk("R8 new descriptor next", dsp_limit, 32);
  endtask

  task automatic t_backpressure();
    set_stat(3, 2'b01);
    @(negedge clk);
    dsp_ready = 1'b0;
    grant(3);
    chk("R9 first held valid", dsp_valid, 1);
    gnt_valid = 1'b1; gnt_chan = 10;
    #1 chk("R9 gnt_ready low", gnt_ready, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 held chan", dsp_chan, 3);
    chk("R9 held limit", dsp_limit, 64);
    dsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    gnt_valid = 1'b0;
    chk("R9 next record chan", dsp_chan, 10);
    chk("R9 next record limit", dsp_limit, 32);
    @(posedge clk);
    @(negedge clk);
    chk("R9 drained", dsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_reject();
    t_limits();
    t_routes();
    t_sat();
    t_same_edge();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule